// File: doc/BRIEF.md
# Streaming 9/7 Lifting Wavelet Step

This block applies one forward level of the 9/7 biorthogonal wavelet to a one-dimensional line of signed samples. Samples enter as pairs, one even and one odd sample per cycle. The first pair and the last pair of each line are marked with flags. For every input pair the block emits one low-pass and one high-pass coefficient, in the same order as the input. Line ends use symmetric extension, so a line can be of any length from one pair upward.

The arithmetic runs as four lifting stages and then a scaling step. The stages are predict, update, predict and update, and each one adds a constant times a neighbour sum to one half of the pair. Every constant multiply uses small product tables that are indexed by 4-bit slices of the variable operand. The top slice carries a negative weight, so signed operands give exact products. A build-time placement parameter decides where registers go: at the block edge only, also after every lifting stage, or also inside every multiplier. The coefficients are bit-identical in all three placements. Only the latency changes.

Top module: `dwt97_lift`

## Requirements
- R1: While reset is high, and on the cycle after it falls, out_valid is 0. Any pair accepted before a reset never produces an output.
- R2: Each low output equals floor(s2*74/64). Here d1 = o + floor(-102*(e[n]+e[n+1])/64), s1 = e + floor(-3*(d1[n-1]+d1[n])/64), d2 = d1 + floor(57*(s1[n]+s1[n+1])/64) and s2 = s1 + floor(28*(d2[n-1]+d2[n])/64). All constants are signed with 6 fractional bits.
- R3: Each high output equals floor(d2*56/64), with d2 as defined in R2.
- R4: In the last pair of a line, the missing right neighbour in both predict stages is replaced by the pair's own even-side value.
- R5: In the first pair of a line, the missing left neighbour in both update stages is replaced by the pair's own odd-side value.
- R6: A line of one pair (first and last both set) gives coefficients under R4 and R5 applied together.
- R7: Full-scale 11-bit two's complement inputs (-1024 and 1023) give exact R2/R3 results.
- R8: For a one-pair line sent into an idle block, out_valid rises 4, 8 or 18 rising edges after the edge that captures the pair. These values apply for placement 0 (edge registers only), 1 (plus one register per lifting stage) and 2 (plus two registers in every multiplier), respectively.
- R9: The three placements give identical coefficient sequences for the same input.
- R10: There is exactly one output per input pair, in input order. out_first and out_last repeat the flags of the matching input pair. An output never starts a line while the previous line is open, or continues a line that was never opened.
- R11: Pairs may arrive on every cycle with no gaps, including a new line starting on the cycle right after a last pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample pair is present this cycle |
| in_first | input | 1 | Pair is the first of its line |
| in_last | input | 1 | Pair is the last of its line |
| in_even | input | IN_W (11) | Even-position sample, two's complement |
| in_odd | input | IN_W (11) | Odd-position sample, two's complement |
| out_valid | output | 1 | A coefficient pair is present |
| out_first | output | 1 | Coefficients belong to a line's first pair |
| out_last | output | 1 | Coefficients belong to a line's last pair |
| out_low | output | 16 | Low-pass coefficient, two's complement |
| out_high | output | 16 | High-pass coefficient, two's complement |

## Verification
The sharpest coincidence occurs at a line boundary. A predict stage must flush a held last pair, using its own even value as the right neighbour, in the same cycle that it accepts the first pair of the next line. The first update stage then sees that new first pair one pair later and must not reuse the previous line's odd value. The stimulus table sends several lines back to back with no idle cycle between them, in all three placements at once. Every coefficient, flag and output count is judged against an integer model of the quantised lifting equations, and the three placements are compared with each other.

// File: rtl/dwt97_pkg.sv
package dwt97_pkg;

    localparam int DW   = 16;           // internal sample width
    localparam int CW   = 8;            // constant width
    localparam int FRAC = 6;            // fractional bits of constants
    localparam int SL   = 4;            // operand slice width for table lookup
    localparam int NSL  = DW / SL;      // number of slices
    localparam int TW   = SL + CW;      // table entry width
    localparam int PW   = DW + CW;      // full product width
    localparam int NENT = 1 << SL;      // entries per table

    typedef enum logic [1:0] {
        PL_IO_ONLY = 2'd0,
        PL_STAGE   = 2'd1,
        PL_FULL    = 2'd2
    } place_e;

    typedef enum logic {
        LK_PREDICT = 1'b0,
        LK_UPDATE  = 1'b1
    } lift_kind_e;

    typedef logic signed [DW-1:0] samp_t;

    typedef struct packed {
        logic  vld;
        logic  first;
        logic  last;
        samp_t ev;
        samp_t od;
    } pair_t;

    localparam logic signed [CW-1:0] K_ALPHA = -8'sd102;
    localparam logic signed [CW-1:0] K_BETA  = -8'sd3;
    localparam logic signed [CW-1:0] K_GAMMA =  8'sd57;
    localparam logic signed [CW-1:0] K_DELTA =  8'sd28;
    localparam logic signed [CW-1:0] K_LO    =  8'sd74;
    localparam logic signed [CW-1:0] K_HI    =  8'sd56;

    typedef logic [NENT-1:0][TW-1:0] rom_t;

    // Product table for one slice; the top slice is read with negative weight.
    function automatic rom_t build_rom(input logic signed [CW-1:0] k, input logic top);
        rom_t r;
        for (int v = 0; v < NENT; v++) begin
            int sv;
            sv   = (top && v >= NENT / 2) ? v - NENT : v;
            r[v] = TW'(sv * int'(k));
        end
        return r;
    endfunction

    function automatic logic signed [CW-1:0] stage_coef(input int g);
        case (g)
            0:       return K_ALPHA;
            1:       return K_BETA;
            2:       return K_GAMMA;
            default: return K_DELTA;
        endcase
    endfunction

endpackage

// File: rtl/dwt97_delay.sv
module dwt97_delay #(
    parameter int LAT = 2,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (LAT == 0) begin : g_wire
            assign q = d;
        end else begin : g_reg
            logic [W-1:0] sr [LAT];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < LAT; i++) sr[i] <= '0;
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < LAT; i++) sr[i] <= sr[i-1];
                end
            end
            assign q = sr[LAT-1];
        end
    endgenerate

endmodule

// File: rtl/dwt97_kmul.sv
module dwt97_kmul import dwt97_pkg::*; #(
    parameter logic signed [CW-1:0] COEF = K_ALPHA,
    parameter bit                   PIPE = 1'b1
) (
    input  logic                 clk,
    input  logic signed [DW-1:0] x,
    output logic signed [PW-1:0] p
);

    logic signed [TW-1:0] part   [NSL];
    logic signed [TW-1:0] part_q [NSL];
    logic signed [PW-1:0] acc;

    // One product table per operand slice, addressed by the slice value.
    generate
        for (genvar g = 0; g < NSL; g++) begin : g_slice
            localparam rom_t ROM = build_rom(COEF, (g == NSL - 1));
            assign part[g] = $signed(ROM[x[g*SL +: SL]]);
        end
    endgenerate

    generate
        if (PIPE) begin : g_part_reg
            always_ff @(posedge clk) part_q <= part;
        end else begin : g_part_comb
            always_comb part_q = part;
        end
    endgenerate

    // Shift-and-add of the slice products.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NSL; i++) begin
            acc = acc + (PW'(part_q[i]) <<< (SL * i));
        end
    end

    generate
        if (PIPE) begin : g_sum_reg
            always_ff @(posedge clk) p <= acc;
        end else begin : g_sum_comb
            assign p = acc;
        end
    endgenerate

endmodule

// File: rtl/dwt97_stage.sv
module dwt97_stage import dwt97_pkg::*; #(
    parameter lift_kind_e           KIND  = LK_PREDICT,
    parameter logic signed [CW-1:0] COEF  = K_ALPHA,
    parameter bit                   MPIPE = 1'b1,
    parameter bit                   SREG  = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  pair_t din,
    output pair_t dout
);

    localparam int ML = MPIPE ? 2 : 0;

    pair_t                em;
    pair_t                emd;
    pair_t                res;
    samp_t                nsum;
    samp_t                scaled;
    logic signed [PW-1:0] prod;

    generate
        if (KIND == LK_PREDICT) begin : g_pred
            // Holds a pair until its right neighbour arrives or the line ends.
            pair_t hold;
            always_ff @(posedge clk) begin
                if (rst)           hold     <= '0;
                else if (din.vld)  hold     <= din;
                else if (em.vld)   hold.vld <= 1'b0;
            end
            always_comb begin
                em     = hold;
                em.vld = hold.vld & (hold.last | din.vld);
                nsum   = hold.ev + (hold.last ? hold.ev : din.ev);
            end
        end else begin : g_upd
            // Keeps the previous odd-side value of the line.
            samp_t prev_d;
            always_ff @(posedge clk) begin
                if (rst)          prev_d <= '0;
                else if (din.vld) prev_d <= din.od;
            end
            always_comb begin
                em   = din;
                nsum = din.od + (din.first ? din.od : prev_d);
            end
        end
    endgenerate

    dwt97_kmul #(.COEF(COEF), .PIPE(MPIPE)) u_mul (
        .clk (clk),
        .x   (nsum),
        .p   (prod)
    );

    dwt97_delay #(.LAT(ML), .W($bits(pair_t))) u_align (
        .clk (clk),
        .rst (rst),
        .d   (em),
        .q   (emd)
    );

    assign scaled = DW'(prod >>> FRAC);

    always_comb begin
        res = emd;
        if (KIND == LK_PREDICT) res.od = emd.od + scaled;
        else                    res.ev = emd.ev + scaled;
    end

    generate
        if (SREG) begin : g_sreg
            always_ff @(posedge clk) begin
                if (rst) dout <= '0;
                else     dout <= res;
            end
        end else begin : g_scomb
            assign dout = res;
        end
    endgenerate

endmodule

// File: rtl/dwt97_lift.sv
module dwt97_lift import dwt97_pkg::*; #(
    parameter place_e PLACE = PL_FULL,
    parameter int     IN_W  = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic [IN_W-1:0]      in_even,
    input  logic [IN_W-1:0]      in_odd,
    output logic                 out_valid,
    output logic                 out_first,
    output logic                 out_last,
    output logic signed [DW-1:0] out_low,
    output logic signed [DW-1:0] out_high
);

    localparam bit MP     = (PLACE == PL_FULL);
    localparam bit SR     = (PLACE != PL_IO_ONLY);
    localparam int ML     = MP ? 2 : 0;
    localparam int NSTAGE = 4;

    pair_t                chain [NSTAGE+1];
    pair_t                sc_d;
    logic signed [PW-1:0] p_lo;
    logic signed [PW-1:0] p_hi;

    // Edge input register.
    always_ff @(posedge clk) begin
        if (rst) begin
            chain[0] <= '0;
        end else begin
            chain[0].vld   <= in_valid;
            chain[0].first <= in_first;
            chain[0].last  <= in_last;
            chain[0].ev    <= DW'($signed(in_even));
            chain[0].od    <= DW'($signed(in_odd));
        end
    end

    // Predict / update / predict / update.
    generate
        for (genvar g = 0; g < NSTAGE; g++) begin : g_lift
            dwt97_stage #(
                .KIND  ((g % 2 == 0) ? LK_PREDICT : LK_UPDATE),
                .COEF  (stage_coef(g)),
                .MPIPE (MP),
                .SREG  (SR)
            ) u_stage (
                .clk  (clk),
                .rst  (rst),
                .din  (chain[g]),
                .dout (chain[g+1])
            );
        end
    endgenerate

    // Output scaling, one multiplier per branch.
    dwt97_kmul #(.COEF(K_LO), .PIPE(MP)) u_mul_lo (
        .clk (clk),
        .x   (chain[NSTAGE].ev),
        .p   (p_lo)
    );

    dwt97_kmul #(.COEF(K_HI), .PIPE(MP)) u_mul_hi (
        .clk (clk),
        .x   (chain[NSTAGE].od),
        .p   (p_hi)
    );

    dwt97_delay #(.LAT(ML), .W($bits(pair_t))) u_sc_align (
        .clk (clk),
        .rst (rst),
        .d   (chain[NSTAGE]),
        .q   (sc_d)
    );

    // Edge output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            out_low   <= '0;
            out_high  <= '0;
        end else begin
            out_valid <= sc_d.vld;
            out_first <= sc_d.vld & sc_d.first;
            out_last  <= sc_d.vld & sc_d.last;
            out_low   <= DW'(p_lo >>> FRAC);
            out_high  <= DW'(p_hi >>> FRAC);
        end
    end

endmodule

// File: rtl/dwt97_lift_chk.sv
module dwt97_lift_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_first,
    input logic in_last,
    input logic out_valid,
    input logic out_first,
    input logic out_last
);

    logic [7:0] pend;
    logic       mid;
    logic       in_mark;

    assign in_mark = in_valid & (in_first | in_last);

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend + {7'd0, in_valid} - {7'd0, out_valid};
    end

    always_ff @(posedge clk) begin
        if (rst)            mid <= 1'b0;
        else if (out_valid) mid <= ~out_last;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    // R10
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (pend != 8'd0));

    // R10
    line_start_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_first) |-> !mid);

    // R10
    line_cont_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_first) |-> mid);

endmodule

bind dwt97_lift dwt97_lift_chk u_chk (.*);

// File: tb/dwt97_lift_bench.sv
`timescale 1ns/1ps
module dwt97_lift_bench;

    localparam int NV  = 16;
    localparam int NM  = 3;
    localparam int WDG = 20000;

    // Stimulus table: even, odd, first, last per pair; lines back to back.
    localparam int VE [NV] = '{  100,  200, -300,   50,
                                1023,
                               -1024,-1024, 1023,
                                   7,    0, -512,  333,   -1,
                               -1024, 1023,
                                   0 };
    localparam int VO [NV] = '{  -50,   30,  400,  -60,
                               -1024,
                                1023, 1023,-1024,
                                  -7,    0,  511, -200,    1,
                               -1024, 1023,
                                   5 };
    localparam bit VF [NV] = '{1,0,0,0, 1, 1,0,0, 1,0,0,0,0, 1,0, 1};
    localparam bit VL [NV] = '{0,0,0,1, 1, 0,0,1, 0,0,0,0,1, 0,1, 1};
    localparam int LAT_EXP [NM] = '{4, 8, 18};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_first = 1'b0;
    logic in_last  = 1'b0;
    logic [10:0] in_even = '0;
    logic [10:0] in_odd  = '0;

    logic               ov  [NM];
    logic               ofl [NM];
    logic               oll [NM];
    logic signed [15:0] olo [NM];
    logic signed [15:0] ohi [NM];

    int n_chk = 0;
    int n_err = 0;
    int exp_lo [NV];
    int exp_hi [NV];
    int cap_lo [NM][2*NV];
    int cap_hi [NM][2*NV];
    bit cap_f  [NM][2*NV];
    bit cap_l  [NM][2*NV];
    int cap_n  [NM];

    always #10 clk = ~clk;

    generate
        for (genvar k = 0; k < NM; k++) begin : g_mode
            dwt97_lift #(.PLACE(dwt97_pkg::place_e'(k)), .IN_W(11)) u_dwt97_lift (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (in_valid),
                .in_first  (in_first),
                .in_last   (in_last),
                .in_even   (in_even),
                .in_odd    (in_odd),
                .out_valid (ov[k]),
                .out_first (ofl[k]),
                .out_last  (oll[k]),
                .out_low   (olo[k]),
                .out_high  (ohi[k])
            );
        end
    endgenerate

    always @(negedge clk) begin
        for (int k = 0; k < NM; k++) begin
            if (ov[k] && cap_n[k] < 2*NV) begin
                cap_lo[k][cap_n[k]] = int'(olo[k]);
                cap_hi[k][cap_n[k]] = int'(ohi[k]);
                cap_f[k][cap_n[k]]  = ofl[k];
                cap_l[k][cap_n[k]]  = oll[k];
                cap_n[k]++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int fl6(input int x);
        return x >>> 6;
    endfunction

    // Integer model of the quantised lifting equations for one line.
    task automatic ref_line(input int a, input int b);
        int n;
        int d1 [NV];
        int s1 [NV];
        int d2 [NV];
        int s2 [NV];
        n = b - a + 1;
        for (int j = 0; j < n; j++) begin
            int en;
            en = (j == n-1) ? VE[a+j] : VE[a+j+1];
            d1[j] = VO[a+j] + fl6((VE[a+j] + en) * -102);
        end
        for (int j = 0; j < n; j++) begin
            int dp;
            dp = (j == 0) ? d1[0] : d1[j-1];
            s1[j] = VE[a+j] + fl6((dp + d1[j]) * -3);
        end
        for (int j = 0; j < n; j++) begin
            int sn;
            sn = (j == n-1) ? s1[j] : s1[j+1];
            d2[j] = d1[j] + fl6((s1[j] + sn) * 57);
        end
        for (int j = 0; j < n; j++) begin
            int dp;
            dp = (j == 0) ? d2[0] : d2[j-1];
            s2[j] = s1[j] + fl6((dp + d2[j]) * 28);
        end
        for (int j = 0; j < n; j++) begin
            exp_lo[a+j] = fl6(s2[j] * 74);
            exp_hi[a+j] = fl6(d2[j] * 56);
        end
    endtask

    function automatic string tag_of(input int i, input bit hi);
        if (VF[i] && VL[i]) return "R6";
        if (VL[i]) return "R4";
        if (VF[i]) return "R5";
        if (VE[i] >= 1023 || VE[i] <= -1024 || VO[i] >= 1023 || VO[i] <= -1024) return "R7";
        return hi ? "R3" : "R2";
    endfunction

    task automatic drive_pair(input int i);
        @(negedge clk);
        in_valid = 1'b1;
        in_first = VF[i];
        in_last  = VL[i];
        in_even  = 11'(VE[i]);
        in_odd   = 11'(VO[i]);
    endtask

    task automatic idle_inputs();
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (WDG) @(posedge clk);
        n_err++;
        $display("FAIL R11 watchdog: actual=%0d cycles expected=fewer", WDG);
        finish_run();
    end

    initial begin
        int s;
        s = 0;
        for (int k = 0; k < NM; k++) cap_n[k] = 0;
        for (int i = 0; i < NV; i++) begin
            if (VF[i]) s = i;
            if (VL[i]) ref_line(s, i);
        end

        repeat (3) @(posedge clk);
        for (int k = 0; k < NM; k++) chk(ov[k] == 1'b0, "R1", "valid during reset", int'(ov[k]), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < NM; k++) chk(ov[k] == 1'b0, "R1", "valid after reset", int'(ov[k]), 0);

        // Table walk: all lines back to back, one pair per cycle (R11).
        for (int i = 0; i < NV; i++) drive_pair(i);
        idle_inputs();
        repeat (60) @(negedge clk);

        for (int k = 0; k < NM; k++) begin
            chk(cap_n[k] == NV, "R11", $sformatf("output count mode %0d", k), cap_n[k], NV);
            for (int i = 0; i < NV; i++) begin
                chk(cap_lo[k][i] == exp_lo[i], tag_of(i, 1'b0),
                    $sformatf("low mode %0d pair %0d", k, i), cap_lo[k][i], exp_lo[i]);
                chk(cap_hi[k][i] == exp_hi[i], tag_of(i, 1'b1),
                    $sformatf("high mode %0d pair %0d", k, i), cap_hi[k][i], exp_hi[i]);
                chk(cap_f[k][i] == VF[i] && cap_l[k][i] == VL[i], "R10",
                    $sformatf("flags mode %0d pair %0d", k, i),
                    int'({cap_f[k][i], cap_l[k][i]}), int'({VF[i], VL[i]}));
            end
        end
        for (int k = 1; k < NM; k++) begin
            for (int i = 0; i < NV; i++) begin
                chk(cap_lo[k][i] == cap_lo[0][i] && cap_hi[k][i] == cap_hi[0][i], "R9",
                    $sformatf("mode %0d vs mode 0 pair %0d low", k, i), cap_lo[k][i], cap_lo[0][i]);
            end
        end

        // Latency of a one-pair line into an idle block (R8).
        begin
            int lat [NM];
            for (int k = 0; k < NM; k++) begin
                lat[k] = 0;
                cap_n[k] = 0;
            end
            drive_pair(NV-1);
            for (int c = 1; c <= 40; c++) begin
                @(posedge clk);
                @(negedge clk);
                if (c == 1) begin
                    in_valid = 1'b0;
                    in_first = 1'b0;
                    in_last  = 1'b0;
                end
                for (int k = 0; k < NM; k++) if (ov[k] && lat[k] == 0) lat[k] = c;
            end
            for (int k = 0; k < NM; k++) begin
                chk(lat[k] == LAT_EXP[k], "R8", $sformatf("latency mode %0d", k), lat[k], LAT_EXP[k]);
                chk(cap_n[k] == 1 && cap_lo[k][0] == exp_lo[NV-1], "R6",
                    $sformatf("isolated pair low mode %0d", k), cap_lo[k][0], exp_lo[NV-1]);
            end
        end

        // Reset in the middle of a line discards held pairs (R1).
        for (int k = 0; k < NM; k++) cap_n[k] = 0;
        for (int i = 0; i < 3; i++) drive_pair(i);
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (30) @(negedge clk);
        for (int k = 0; k < NM; k++)
            chk(cap_n[k] == 0, "R1", $sformatf("outputs after mid-line reset mode %0d", k), cap_n[k], 0);

        // Clean restart after that reset.
        drive_pair(4);
        idle_inputs();
        repeat (30) @(negedge clk);
        for (int k = 0; k < NM; k++) begin
            chk(cap_n[k] == 1, "R10", $sformatf("restart count mode %0d", k), cap_n[k], 1);
            chk(cap_hi[k][0] == exp_hi[4], "R7", $sformatf("restart high mode %0d", k),
                cap_hi[k][0], exp_hi[4]);
        end

        finish_run();
    end

endmodule